// File: doc/BRIEF.md
# Frame-Synchronized Command Sequencer

This block holds register-write commands (an address and a data word) in sixteen per-frame queues. It releases them on an output command bus, either at once or when a chosen later video frame begins. A 4-bit frame counter selects which queue is active. The counter advances on each frame-start pulse while the sequencer runs. The active queue drains one command per cycle whenever the downstream side accepts it.

The host writes into a 32-word window selected by a 5-bit offset. Offset 31 is a control word. Every other offset takes a command as two writes: the first carries the target register address and the second carries the data. Offsets 0 to 15 name an absolute frame slot. Offsets 16 to 30 name a slot relative to the current frame. The control word runs or stops the sequencer, flushes every queue, and manages a frame-drained interrupt.

The sequencing engine has three named states:
- `ST_STOP`: stopped. This is the state after reset.
- `ST_RUN`: running.
- `ST_FLUSH`: flushing the queues.

It has five transitions:
- `STOP->RUN` on a run command.
- `RUN->STOP` on a stop command.
- `STOP->FLUSH` on a control word with the flush bit set.
- `RUN->FLUSH` on a control word with the flush bit set.
- `FLUSH->STOP` when the flush timer expires.

Top module: `frame_cmd_seq`

## Requirements
- R1: After reset the outputs are as follows: `cmd_valid`=0, `running`=0, `busy`=0, `ovf`=0, `irq`=0, `cur_frame`=0, and the address/data write toggle expects an address.
- R2: A write to any offset other than 31 alternates between two roles. A first write latches `wr_data[ADDR_W-1:0]` as the address. The next write supplies the data and queues the pair. A write to offset 31 returns the toggle to the address role.
- R3: For offsets 0..15, the command goes to frame slot `wr_off[3:0]`. If that slot equals `cur_frame-1` (mod 16), the frame has just been missed and the command goes to slot `cur_frame` instead.
- R4: Offset 16+k (k = 0..14) queues the command for frame `cur_frame+k` (mod 16). Offset 16 therefore issues as soon as possible.
- R5: `cmd_valid` is high while running and the queue of `cur_frame` is not empty. Address and data hold steady until `cmd_ready`. One command leaves per accepted cycle, in the order it was written to that slot.
- R6: A `frame_start` pulse seen while running adds one to `cur_frame` (mod 16) on the next edge. While stopped or flushing, `cur_frame` does not change.
- R7: Control bits [13:12] set the run state: 3 runs and 2 stops. The values 0 and 1 leave the run state unchanged. Stopping keeps every queued command for when running resumes.
- R8: Control bit 14 flushes the queues. It has priority over the run bits in the same word. `busy` stays high for exactly FLUSH_CYC (32) cycles. During that time host writes and frame pulses are ignored. Afterwards every queue is empty, `ovf` is 0, and the state is stopped.
- R9: Each slot holds DEPTH (8) commands. A command aimed at a full slot is dropped and sets the sticky `ovf` flag, which only a flush clears.
- R10: The drained status bit sets once the active queue is empty after a running frame advance. Control bits [1:0] act on the interrupt: 0 does nothing, 1 clears the status bit, 2 clears the enable, and 3 sets the enable.
- R11: `irq` equals the drained status bit ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a video frame |
| wr_en | input | 1 | Host write strobe |
| wr_off | input | 5 | Host write offset (0..30 command slots, 31 control) |
| wr_data | input | DATA_W | Host write data |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_addr | output | ADDR_W | Presented register address |
| cmd_data | output | DATA_W | Presented register data |
| cur_frame | output | 4 | Current frame counter |
| running | output | 1 | Sequencer in the run state |
| busy | output | 1 | Queue flush in progress |
| ovf | output | 1 | Sticky dropped-command flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong queue pointer or slot choice shows up at `cmd_data` in the first frame that drains the affected slot. That is at most sixteen frame pulses after the write. A sweep over every offset, from two starting frames, catches it as a wrong count or a wrong word in a specific frame. A wrong state or wrong counter shows within one cycle as a wrong value on `running`, `busy` or `cur_frame`. The flush length is counted cycle by cycle at `busy`. A fault in the interrupt logic shows at `irq` one cycle after the last pop or after a control write.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int FRAME_W    = 4;
    localparam int NUM_SLOTS  = 1 << FRAME_W;
    localparam int OFF_W      = 5;
    localparam logic [OFF_W-1:0] CTRL_OFF = 5'h1f;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } seq_state_t;

    // decoded control word
    typedef struct packed {
        logic       flush;
        logic [1:0] run;
        logic [1:0] irq;
    } ctl_cmd_t;
endpackage

// File: rtl/fcs_queue.sv
module fcs_queue #(
    parameter int W     = 48,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wp, rp;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp[PW-1:0]] <= pdata;
    end

    assign rdata = mem[rp[PW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
endmodule

// File: rtl/fcs_queue_bank.sv
module fcs_queue_bank
    import fcs_pkg::*;
#(
    parameter int W     = 48,
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               push,
    input  logic [FRAME_W-1:0] push_idx,
    input  logic [W-1:0]       pdata,
    input  logic               pop,
    input  logic [FRAME_W-1:0] pop_idx,
    output logic [W-1:0]       rdata,
    output logic [NUM_SLOTS-1:0] empty_vec,
    output logic [NUM_SLOTS-1:0] full_vec
);
    logic [W-1:0] slot_data [NUM_SLOTS];

    for (genvar q = 0; q < NUM_SLOTS; q++) begin : g_slot
        fcs_queue #(.W(W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .push  (push && (push_idx == FRAME_W'(q))),
            .pdata (pdata),
            .pop   (pop && (pop_idx == FRAME_W'(q))),
            .rdata (slot_data[q]),
            .empty (empty_vec[q]),
            .full  (full_vec[q])
        );
    end

    assign rdata = slot_data[pop_idx];
endmodule

// File: rtl/fcs_host_decode.sv
module fcs_host_decode
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [FRAME_W-1:0] cur_frame,
    output logic               push,
    output logic [FRAME_W-1:0] push_idx,
    output logic [ADDR_W+DATA_W-1:0] push_word,
    output logic               ctl_we,
    output ctl_cmd_t           ctl_cmd
);
    logic              data_phase;
    logic [ADDR_W-1:0] addr_q;
    logic              is_ctl;
    logic [FRAME_W-1:0] slot_off;

    assign is_ctl   = (wr_off == CTRL_OFF);
    assign slot_off = wr_off[FRAME_W-1:0];

    // two-write toggle; the control location returns it to the address role
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_phase <= 1'b0;
            addr_q     <= '0;
        end else if (wr_en) begin
            if (is_ctl) begin
                data_phase <= 1'b0;
            end else if (!data_phase) begin
                addr_q     <= wr_data[ADDR_W-1:0];
                data_phase <= 1'b1;
            end else begin
                data_phase <= 1'b0;
            end
        end
    end

    always_comb begin
        if (wr_off[OFF_W-1]) begin
            push_idx = cur_frame + slot_off;          // relative slot
        end else if (slot_off == cur_frame - 1'b1) begin
            push_idx = cur_frame;                     // just missed
        end else begin
            push_idx = slot_off;                      // absolute slot
        end
    end

    assign push      = wr_en && !is_ctl && data_phase;
    assign push_word = {addr_q, wr_data};
    assign ctl_we    = wr_en && is_ctl;
    assign ctl_cmd.flush = wr_data[14];
    assign ctl_cmd.run   = wr_data[13:12];
    assign ctl_cmd.irq   = wr_data[1:0];
endmodule

// File: rtl/fcs_seq_ctrl.sv
module fcs_seq_ctrl
    import fcs_pkg::*;
#(
    parameter int FLUSH_CYC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  ctl_cmd_t           ctl_cmd,
    input  logic               frame_start,
    input  logic               cur_empty,
    input  logic               push_drop,
    output logic               running,
    output logic               flushing,
    output logic [FRAME_W-1:0] cur_frame,
    output logic               ovf,
    output logic               irq
);
    localparam int CW = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1;

    seq_state_t state, state_nx;
    logic [CW-1:0] fl_cnt;
    logic          pend, drained, ien;
    logic          flush_req, run_req, stop_req, set_drained;

    assign flush_req = ctl_we && ctl_cmd.flush;
    assign run_req   = ctl_we && (ctl_cmd.run == 2'd3);
    assign stop_req  = ctl_we && (ctl_cmd.run == 2'd2);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOP: begin
                if (flush_req)    state_nx = ST_FLUSH;
                else if (run_req) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (flush_req)     state_nx = ST_FLUSH;
                else if (stop_req) state_nx = ST_STOP;
            end
            ST_FLUSH: begin
                if (fl_cnt == CW'(FLUSH_CYC - 1)) state_nx = ST_STOP;
            end
            default: state_nx = ST_STOP;
        endcase
    end

    // state-derived outputs
    always_comb begin
        running  = 1'b0;
        flushing = 1'b0;
        unique case (state)
            ST_STOP:  ;
            ST_RUN:   running  = 1'b1;
            ST_FLUSH: flushing = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !flushing) fl_cnt <= '0;
        else                     fl_cnt <= fl_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      cur_frame <= '0;
        else if (running && frame_start) cur_frame <= cur_frame + 1'b1;
    end

    assign set_drained = running && pend && cur_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            drained <= 1'b0;
            ien     <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            if (flushing)                    pend <= 1'b0;
            else if (running && frame_start) pend <= 1'b1;
            else if (set_drained)            pend <= 1'b0;

            if (set_drained)                              drained <= 1'b1;
            else if (ctl_we && ctl_cmd.irq == 2'd1)       drained <= 1'b0;

            if (ctl_we && ctl_cmd.irq == 2'd3)      ien <= 1'b1;
            else if (ctl_we && ctl_cmd.irq == 2'd2) ien <= 1'b0;

            if (flushing)       ovf <= 1'b0;
            else if (push_drop) ovf <= 1'b1;
        end
    end

    assign irq = drained && ien;
endmodule

// File: rtl/frame_cmd_seq.sv
module frame_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 8,
    parameter int FLUSH_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_en,
    input  logic [4:0]        wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [3:0]        cur_frame,
    output logic              running,
    output logic              busy,
    output logic              ovf,
    output logic              irq
);
    localparam int CMD_W = ADDR_W + DATA_W;

    logic               host_we;
    logic               push, accept, drop, pop, ctl_we;
    logic [FRAME_W-1:0] push_idx;
    logic [CMD_W-1:0]   push_word, head_word;
    logic [NUM_SLOTS-1:0] empty_vec, full_vec;
    ctl_cmd_t           ctl_cmd;

    assign host_we = wr_en && !busy;

    fcs_host_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_we),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .cur_frame (cur_frame),
        .push      (push),
        .push_idx  (push_idx),
        .push_word (push_word),
        .ctl_we    (ctl_we),
        .ctl_cmd   (ctl_cmd)
    );

    assign accept = push && !full_vec[push_idx];
    assign drop   = push &&  full_vec[push_idx];

    fcs_queue_bank #(.W(CMD_W), .DEPTH(DEPTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy),
        .push      (accept),
        .push_idx  (push_idx),
        .pdata     (push_word),
        .pop       (pop),
        .pop_idx   (cur_frame),
        .rdata     (head_word),
        .empty_vec (empty_vec),
        .full_vec  (full_vec)
    );

    fcs_seq_ctrl #(.FLUSH_CYC(FLUSH_CYC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_cmd     (ctl_cmd),
        .frame_start (frame_start),
        .cur_empty   (empty_vec[cur_frame]),
        .push_drop   (drop),
        .running     (running),
        .flushing    (busy),
        .cur_frame   (cur_frame),
        .ovf         (ovf),
        .irq         (irq)
    );

    assign cmd_valid = running && !empty_vec[cur_frame];
    assign pop       = cmd_valid && cmd_ready;
    assign cmd_addr  = head_word[CMD_W-1:DATA_W];
    assign cmd_data  = head_word[DATA_W-1:0];
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              wr_en,
    input logic              cmd_ready,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic [3:0]        cur_frame,
    input logic              running,
    input logic              busy,
    input logic              ovf
);
    a_r6_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(cur_frame));

    a_r6_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        running && frame_start |=> cur_frame == $past(cur_frame) + 4'd1);

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !frame_start && !wr_en
        |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data));

    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_valid && !running);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !busy |=> ovf);
endmodule

bind frame_cmd_seq fcs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .wr_en       (wr_en),
    .cmd_ready   (cmd_ready),
    .cmd_valid   (cmd_valid),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .cur_frame   (cur_frame),
    .running     (running),
    .busy        (busy),
    .ovf         (ovf)
);

// File: tb/frame_cmd_seq_tb_top.sv
module frame_cmd_seq_tb_top;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_off = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              cmd_ready = 1'b0;
    logic              cmd_valid;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic [3:0]        cur_frame;
    logic              running, busy, ovf, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [DATA_W-1:0] got_d [32];
    logic [ADDR_W-1:0] got_a [32];
    int got_n;

    always #(CLK_P/2) clk = ~clk;

    frame_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
        .wr_off(wr_off), .wr_data(wr_data), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cur_frame(cur_frame), .running(running), .busy(busy), .ovf(ovf), .irq(irq)
    );

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [4:0] off, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_cmd(input logic [4:0] off, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d);
        host_wr(off, DATA_W'(a));
        host_wr(off, d);
    endtask

    task automatic pulse();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic drain();
        got_n = 0;
        cmd_ready = 1'b1;
        while (cmd_valid && got_n < 32) begin
            got_d[got_n] = cmd_data;
            got_a[got_n] = cmd_addr;
            got_n++;
            @(negedge clk);
        end
        cmd_ready = 1'b0;
    endtask

    function automatic logic [3:0] slot_of(input int off, input logic [3:0] c);
        if (off >= 16) return 4'(c + 4'(off - 16));
        if (4'(off) == 4'(c - 4'd1)) return c;
        return 4'(off);
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cmd_valid", cmd_valid, 0);
        check("R1", "running", running, 0);
        check("R1", "busy", busy, 0);
        check("R1", "ovf", ovf, 0);
        check("R1", "irq", irq, 0);
        check("R1", "cur_frame", cur_frame, 0);

        // R6/R7: stopped keeps commands and ignores frame pulses
        put_cmd(5'h10, 16'h0A0A, 32'h1111_0001);
        check("R7", "valid while stopped", cmd_valid, 0);
        pulse(); pulse();
        check("R6", "frame while stopped", cur_frame, 0);
        host_wr(5'h1f, 32'h0000_1000);
        check("R7", "run code 1 no change", running, 0);
        host_wr(5'h1f, 32'h0000_3000);
        check("R7", "running", running, 1);
        check("R5", "valid after run", cmd_valid, 1);
        check("R2", "addr", cmd_addr, 16'h0A0A);
        check("R2", "data", cmd_data, 32'h1111_0001);
        drain();
        check("R5", "one popped", got_n, 1);

        // R2: control write resets the toggle
        host_wr(5'h10, 32'h0000_BEEF);
        host_wr(5'h1f, 32'h0000_0000);
        put_cmd(5'h10, 16'h0123, 32'h2222_0002);
        check("R2", "toggle addr", cmd_addr, 16'h0123);
        check("R2", "toggle data", cmd_data, 32'h2222_0002);
        drain();
        check("R2", "toggle count", got_n, 1);

        // R7: stop holds queued command, run resumes it
        put_cmd(5'h10, 16'h0077, 32'h3333_0003);
        host_wr(5'h1f, 32'h0000_2000);
        check("R7", "stopped", running, 0);
        check("R7", "valid after stop", cmd_valid, 0);
        pulse();
        check("R6", "frame after stop", cur_frame, 0);
        host_wr(5'h1f, 32'h0000_3000);
        check("R7", "resumed data", cmd_data, 32'h3333_0003);
        drain();

        // R3/R4/R5 sweep over every offset from two start frames
        foreach (got_d[i]) got_d[i] = '0;
        for (int pass = 0; pass < 2; pass++) begin
            automatic logic [3:0] c = (pass == 0) ? 4'd0 : 4'd9;
            while (cur_frame != c) pulse();
            for (int off = 0; off < 31; off++)
                put_cmd(5'(off), 16'(off), 32'hC000_0000 | (32'(c) << 8) | 32'(off));
            for (int s = 0; s < 16; s++) begin
                automatic logic [3:0] n = 4'(c + 4'(s));
                automatic int k = 0;
                drain();
                for (int off = 0; off < 31; off++) begin
                    if (slot_of(off, c) == n) begin
                        if (k < got_n)
                            check(off < 16 ? "R3" : "R4", "slot word", got_d[k],
                                  32'hC000_0000 | (32'(c) << 8) | 32'(off));
                        k++;
                    end
                end
                check("R5", "slot count", got_n, k);
                pulse();
            end
            check("R6", "wrap", cur_frame, c);
        end

        // R9 overflow on a full slot
        for (int i = 0; i < DEPTH; i++) put_cmd(5'h15, 16'(i), 32'h5000_0000 + 32'(i));
        check("R9", "ovf before", ovf, 0);
        put_cmd(5'h15, 16'h00FF, 32'h5000_00FF);
        check("R9", "ovf set", ovf, 1);
        repeat (5) pulse();
        drain();
        check("R9", "kept count", got_n, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            if (i < got_n) check("R5", "order", got_d[i], 32'h5000_0000 + 32'(i));
        check("R9", "ovf sticky", ovf, 1);

        // R10/R11 interrupt
        host_wr(5'h1f, 32'h0000_0003);
        host_wr(5'h1f, 32'h0000_0001);
        check("R10", "cleared", irq, 0);
        put_cmd(5'h11, 16'h0001, 32'h6000_0001);
        put_cmd(5'h11, 16'h0002, 32'h6000_0002);
        pulse();
        check("R10", "not drained yet", irq, 0);
        drain();
        check("R5", "irq slot count", got_n, 2);
        @(negedge clk);
        check("R10", "drained irq", irq, 1);
        host_wr(5'h1f, 32'h0000_0001);
        check("R10", "clear status", irq, 0);
        host_wr(5'h1f, 32'h0000_0002);
        pulse();
        @(negedge clk);
        check("R11", "masked", irq, 0);
        host_wr(5'h1f, 32'h0000_0003);
        check("R11", "unmasked", irq, 1);
        host_wr(5'h1f, 32'h0000_0001);

        // R8 flush
        begin
            automatic logic [3:0] f0 = cur_frame;
            automatic int n = 0;
            put_cmd(5'h12, 16'h0009, 32'h7000_0009);
            host_wr(5'h1f, 32'h0000_7000);
            check("R8", "busy", busy, 1);
            put_cmd(5'h10, 16'h0008, 32'h7000_0008);
            pulse();
            while (busy && n < 100) begin n++; @(negedge clk); end
            check("R8", "busy length", n + 3, 32);
            check("R8", "stopped after", running, 0);
            check("R8", "frame kept", cur_frame, f0);
            check("R8", "ovf cleared", ovf, 0);
            host_wr(5'h1f, 32'h0000_3000);
            check("R8", "empty now", cmd_valid, 0);
            pulse(); pulse();
            check("R8", "empty later", cmd_valid, 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule